// File: doc/BRIEF.md
# Register Bank Conflict Stall Counter

This block examines the source operands of one instruction and works out how many extra operand-read cycles its register bank conflicts will cost. Each bank delivers one dword per cycle, so every extra read that lands on a bank already claimed by the same instruction adds a cycle. Vector registers and scalar registers use two separate banking schemes that share one 12-bit bank mask. Vector registers interleave over four banks one register at a time. Scalar registers interleave over eight banks in aligned pairs.

Each operand slot carries a valid flag, a file selector (vector or scalar), a base register index, a size in dwords and an ignore flag. The block reports three things: the accumulated bank-usage mask, the bank mask each operand contributes, and the stall count. A new instruction can be presented on every cycle. Its result appears one clock later from a register stage, and that stage keeps its last result while no new instruction is offered.

Top module: `bank_conflict_counter`

## Requirements
- R1: A vector operand dword with register number r uses bank r mod 4, which is bit (r mod 4) of the 12-bit mask (bits 0 to 3).
- R2: A scalar operand dword with register number r uses scalar bank (r / 2) mod 8, which is mask bit 4 + ((r / 2) mod 8). Each unit is a pair of scalar registers.
- R3: The operand size is clamped to MAX_DW dwords (default 4). A vector operand covers that many consecutive registers from its base. Its bank bits wrap modulo 4.
- R4: A scalar operand covers size/2 pair units when its clamped size is above one, and one pair unit otherwise. The units start at pair (index / 2) and wrap modulo 8 within bits 4 to 11.
- R5: A unit (a vector register, or a scalar pair) that an earlier live operand of the same file already covers adds no bank bit to a later operand. Two scalar registers in the same pair therefore never conflict with each other.
- R6: An operand with valid low, ignore high or size 0 is not live. Its mask is zero, it adds no stall, and it does not suppress units of later operands.
- R7: Operands are processed in slot order 0, 1, 2. Each one adds popcount(accumulated mask AND its own mask) to the stall count and then ORs its mask into the accumulator. For example, vector registers 0, 4 and 8 give a stall count of 2.
- R8: The reported usage mask is the OR of the reported per-operand masks.
- R9: Results appear on the outputs one clock after in_valid is sampled high. out_valid equals in_valid delayed by one clock.
- R10: While in_valid is low, the usage mask, the per-operand masks and the stall count keep their values.
- R11: An asynchronous active-low reset clears out_valid, both masks and the stall count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| op_valid | input | NOPS | Per-slot operand present |
| op_scalar | input | NOPS | Per-slot file select: 1 = scalar, 0 = vector |
| op_ignore | input | NOPS | Per-slot operand excluded from the analysis |
| op_index | input | NOPS*IDX_W | Per-slot base register number, slot k at [k*IDX_W +: IDX_W] |
| op_size | input | NOPS*SZ_W | Per-slot size in dwords, slot k at [k*SZ_W +: SZ_W] |
| out_valid | output | 1 | The result registers hold a fresh result |
| out_used | output | 12 | Accumulated bank-usage mask |
| out_op_mask | output | NOPS*12 | Per-slot bank mask, slot k at [k*12 +: 12] |
| out_stall | output | STALL_W | Extra read cycles caused by conflicts |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle valid delay;
- holding of the result while no instruction is offered;
- equality of the usage mask with the OR of the per-slot masks;
- a zero mask for every slot that was not live;
- an upper bound on the stall count given by the later slots' masks.

Other behaviour can only be shown by the bench's scenarios, which compare against values computed from the banking rules:
- the exact bank arithmetic for both files;
- wrapping of multi-dword operands;
- the pairing of scalar registers;
- suppression of repeated units;
- the exact stall totals.

The bench sweeps every pair of small vector operands and every pair of small scalar operands, then runs a mixed random phase with ignored, invalid, zero-size and oversize slots.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  localparam int VEC_BANKS = 4;
  localparam int SCL_BANKS = 8;
  localparam int SCL_OFS   = VEC_BANKS;
  localparam int MASK_W    = VEC_BANKS + SCL_BANKS;
  localparam int VB_W      = $clog2(VEC_BANKS);
  localparam int SB_W      = $clog2(SCL_BANKS);
  localparam int POP_W     = $clog2(MASK_W + 1);

  typedef logic [MASK_W-1:0] bank_mask_t;

  function automatic logic [POP_W-1:0] mask_pop(input bank_mask_t m);
    logic [POP_W-1:0] n;
    n = '0;
    for (int b = 0; b < MASK_W; b++) begin
      n = n + POP_W'(m[b]);
    end
    return n;
  endfunction

endpackage

// File: rtl/rbc_operand_span.sv
module rbc_operand_span #(
  parameter int IDX_W  = 8,
  parameter int SZ_W   = 3,
  parameter int MAX_DW = 4
) (
  input  logic             valid,
  input  logic             scalar,
  input  logic             ignore,
  input  logic [IDX_W-1:0] index,
  input  logic [SZ_W-1:0]  size,
  output logic             live,
  output logic [IDX_W-1:0] base,
  output logic [SZ_W-1:0]  count
);

  localparam logic [SZ_W-1:0] MAX_SZ = SZ_W'(MAX_DW);
  localparam logic [SZ_W-1:0] ONE_SZ = SZ_W'(1);

  logic [SZ_W-1:0] clamped;

  always_comb begin
    clamped = (size > MAX_SZ) ? MAX_SZ : size;
    live    = valid & ~ignore & (size != '0);
    if (scalar) begin
      // scalar units are aligned register pairs
      base  = {1'b0, index[IDX_W-1:1]};
      count = (clamped > ONE_SZ) ? (clamped >> 1) : ONE_SZ;
    end else begin
      base  = index;
      count = clamped;
    end
  end

endmodule

// File: rtl/rbc_operand_mask.sv
module rbc_operand_mask
  import rbc_pkg::*;
#(
  parameter int NOPS   = 3,
  parameter int POS    = 0,
  parameter int UW     = 8,
  parameter int CW     = 3,
  parameter int MAX_DW = 4
) (
  input  logic [NOPS-1:0]    all_live,
  input  logic [NOPS-1:0]    all_scalar,
  input  logic [NOPS*UW-1:0] all_base,
  input  logic [NOPS*CW-1:0] all_count,
  output bank_mask_t         mask
);

  logic          own_live;
  logic          own_scal;
  logic [UW-1:0] own_base;
  logic [CW-1:0] own_count;
  logic [UW:0]   unit;
  logic [UW:0]   lo;
  logic [UW:0]   hi;
  logic          taken;

  assign own_live  = all_live[POS];
  assign own_scal  = all_scalar[POS];
  assign own_base  = all_base[POS*UW +: UW];
  assign own_count = all_count[POS*CW +: CW];

  always_comb begin
    mask  = '0;
    unit  = '0;
    lo    = '0;
    hi    = '0;
    taken = 1'b0;
    for (int j = 0; j < MAX_DW; j++) begin
      unit  = {1'b0, own_base} + (UW+1)'(j);
      taken = 1'b0;
      // a unit claimed by an earlier live operand of the same file is skipped
      for (int i = 0; i < NOPS; i++) begin
        lo = {1'b0, all_base[i*UW +: UW]};
        hi = lo + (UW+1)'(all_count[i*CW +: CW]);
        if ((i < POS) && all_live[i] && (all_scalar[i] == own_scal) &&
            (unit >= lo) && (unit < hi)) begin
          taken = 1'b1;
        end
      end
      if (own_live && (j < int'(own_count)) && !taken) begin
        if (own_scal) begin
          mask[SCL_OFS + int'(unit[SB_W-1:0])] = 1'b1;
        end else begin
          mask[int'(unit[VB_W-1:0])] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rbc_stall_accum.sv
module rbc_stall_accum
  import rbc_pkg::*;
#(
  parameter int NOPS    = 3,
  parameter int STALL_W = 4
) (
  input  logic [NOPS*MASK_W-1:0] masks,
  output bank_mask_t             used,
  output logic [STALL_W-1:0]     stall
);

  bank_mask_t acc;
  int         total;

  always_comb begin
    acc   = '0;
    total = 0;
    for (int k = 0; k < NOPS; k++) begin
      total = total + int'(mask_pop(acc & masks[k*MASK_W +: MASK_W]));
      acc   = acc | masks[k*MASK_W +: MASK_W];
    end
    used  = acc;
    stall = STALL_W'(total);
  end

endmodule

// File: rtl/bank_conflict_counter.sv
module bank_conflict_counter
  import rbc_pkg::*;
#(
  parameter int NOPS    = 3,
  parameter int IDX_W   = 8,
  parameter int MAX_DW  = 4,
  parameter int SZ_W    = $clog2(MAX_DW + 1),
  parameter int STALL_W = $clog2((NOPS - 1) * MAX_DW + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [NOPS-1:0]         op_valid,
  input  logic [NOPS-1:0]         op_scalar,
  input  logic [NOPS-1:0]         op_ignore,
  input  logic [NOPS*IDX_W-1:0]   op_index,
  input  logic [NOPS*SZ_W-1:0]    op_size,
  output logic                    out_valid,
  output logic [MASK_W-1:0]       out_used,
  output logic [NOPS*MASK_W-1:0]  out_op_mask,
  output logic [STALL_W-1:0]      out_stall
);

  logic [NOPS-1:0]        op_live;
  logic [NOPS*IDX_W-1:0]  op_base;
  logic [NOPS*SZ_W-1:0]   op_cnt;
  logic [NOPS*MASK_W-1:0] mask_c;
  bank_mask_t             used_c;
  logic [STALL_W-1:0]     stall_c;

  genvar k;
  generate
    for (k = 0; k < NOPS; k++) begin : g_slot
      rbc_operand_span #(
        .IDX_W (IDX_W),
        .SZ_W  (SZ_W),
        .MAX_DW(MAX_DW)
      ) u_span (
        .valid (op_valid[k]),
        .scalar(op_scalar[k]),
        .ignore(op_ignore[k]),
        .index (op_index[k*IDX_W +: IDX_W]),
        .size  (op_size[k*SZ_W +: SZ_W]),
        .live  (op_live[k]),
        .base  (op_base[k*IDX_W +: IDX_W]),
        .count (op_cnt[k*SZ_W +: SZ_W])
      );

      rbc_operand_mask #(
        .NOPS  (NOPS),
        .POS   (k),
        .UW    (IDX_W),
        .CW    (SZ_W),
        .MAX_DW(MAX_DW)
      ) u_mask (
        .all_live  (op_live),
        .all_scalar(op_scalar),
        .all_base  (op_base),
        .all_count (op_cnt),
        .mask      (mask_c[k*MASK_W +: MASK_W])
      );
    end
  endgenerate

  rbc_stall_accum #(
    .NOPS   (NOPS),
    .STALL_W(STALL_W)
  ) u_accum (
    .masks(mask_c),
    .used (used_c),
    .stall(stall_c)
  );

  // result register stage: next-state logic
  logic                   vld_d;
  bank_mask_t             used_d;
  logic [NOPS*MASK_W-1:0] omask_d;
  logic [STALL_W-1:0]     stall_d;

  always_comb begin
    vld_d   = in_valid;
    used_d  = out_used;
    omask_d = out_op_mask;
    stall_d = out_stall;
    if (in_valid) begin
      used_d  = used_c;
      omask_d = mask_c;
      stall_d = stall_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_used    <= '0;
      out_op_mask <= '0;
      out_stall   <= '0;
    end else begin
      out_valid   <= vld_d;
      out_used    <= used_d;
      out_op_mask <= omask_d;
      out_stall   <= stall_d;
    end
  end

  // assertion support: union and stall bound over the registered slot masks
  bank_mask_t chk_union;
  int         chk_bound;

  always_comb begin
    chk_union = '0;
    chk_bound = 0;
    for (int s = 0; s < NOPS; s++) begin
      chk_union = chk_union | out_op_mask[s*MASK_W +: MASK_W];
      if (s > 0) begin
        chk_bound = chk_bound + $countones(out_op_mask[s*MASK_W +: MASK_W]);
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_used) && $stable(out_op_mask) && $stable(out_stall)));  // R10
  AST_USED_UNION: assert property (@(posedge clk) disable iff (!rst_n)
    out_used == chk_union);  // R8
  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_stall) <= chk_bound));  // R7

  generate
    for (k = 0; k < NOPS; k++) begin : g_chk
      AST_DEAD_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_live[k]) |=> (out_op_mask[k*MASK_W +: MASK_W] == '0));  // R6
    end
  endgenerate

endmodule

// File: tb/tb_bank_conflict_counter.sv
module tb_bank_conflict_counter;

  localparam int NOPS = 3;
  localparam int IDX_W = 8;
  localparam int SZ_W = 3;
  localparam int SW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst_n;
  logic                in_valid;
  logic [NOPS-1:0]     op_valid, op_scalar, op_ignore;
  logic [NOPS*IDX_W-1:0] op_index;
  logic [NOPS*SZ_W-1:0]  op_size;
  logic                out_valid;
  logic [11:0]         out_used;
  logic [NOPS*12-1:0]  out_op_mask;
  logic [SW-1:0]       out_stall;

  bank_conflict_counter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_valid(op_valid), .op_scalar(op_scalar), .op_ignore(op_ignore),
    .op_index(op_index), .op_size(op_size),
    .out_valid(out_valid), .out_used(out_used),
    .out_op_mask(out_op_mask), .out_stall(out_stall)
  );

  int checks = 0;
  int errors = 0;

  int t_v[NOPS], t_s[NOPS], t_ig[NOPS], t_idx[NOPS], t_sz[NOPS];
  int e_used;
  int e_mask[NOPS];
  int e_stall;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic set_op(input int k, input int v, input int s, input int ig,
                        input int idx, input int sz);
    t_v[k] = v; t_s[k] = s; t_ig[k] = ig; t_idx[k] = idx; t_sz[k] = sz;
  endtask

  // expected values from the banking rules
  task automatic compute_expected();
    int lv[NOPS], lb[NOPS], ln[NOPS];
    int acc;
    for (int k = 0; k < NOPS; k++) begin
      int c;
      lv[k] = (t_v[k] != 0 && t_ig[k] == 0 && t_sz[k] != 0) ? 1 : 0;
      c = (t_sz[k] > 4) ? 4 : t_sz[k];
      if (t_s[k] != 0) begin
        lb[k] = t_idx[k] / 2;
        ln[k] = (c > 1) ? c / 2 : 1;
      end else begin
        lb[k] = t_idx[k];
        ln[k] = c;
      end
      e_mask[k] = 0;
      if (lv[k] != 0) begin
        for (int j = 0; j < ln[k]; j++) begin
          int u;
          int hit;
          u = lb[k] + j;
          hit = 0;
          for (int i = 0; i < k; i++)
            if (lv[i] != 0 && t_s[i] == t_s[k] && u >= lb[i] && u < lb[i] + ln[i]) hit = 1;
          if (hit == 0) begin
            if (t_s[k] != 0) e_mask[k] |= 1 << (4 + (u % 8));
            else e_mask[k] |= 1 << (u % 4);
          end
        end
      end
    end
    acc = 0;
    e_stall = 0;
    for (int k = 0; k < NOPS; k++) begin
      e_stall += $countones(acc & e_mask[k]);
      acc |= e_mask[k];
    end
    e_used = acc;
  endtask

  task automatic drive_ops();
    for (int k = 0; k < NOPS; k++) begin
      op_valid[k]  = t_v[k][0];
      op_scalar[k] = t_s[k][0];
      op_ignore[k] = t_ig[k][0];
      op_index[k*IDX_W +: IDX_W] = t_idx[k][IDX_W-1:0];
      op_size[k*SZ_W +: SZ_W]    = t_sz[k][SZ_W-1:0];
    end
  endtask

  // called at a falling edge; returns at the falling edge after the result
  task automatic run_one(input string tag);
    drive_ops();
    in_valid = 1'b1;
    compute_expected();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "out_valid", int'(out_valid), 1);
    chk(tag, "used", int'(out_used), e_used);
    for (int k = 0; k < NOPS; k++)
      chk(tag, "op_mask", int'(out_op_mask[k*12 +: 12]), e_mask[k]);
    chk(tag, "stall", int'(out_stall), e_stall);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b1;
    op_valid = '1; op_scalar = '0; op_ignore = '0;
    op_index = '0; op_size = '1;
    repeat (3) @(negedge clk);
    // R11: reset dominates a presented instruction
    chk("R11", "out_valid", int'(out_valid), 0);
    chk("R11", "used", int'(out_used), 0);
    chk("R11", "op_mask", int'(out_op_mask), 0);
    chk("R11", "stall", int'(out_stall), 0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);

    // R7 worked example: v0, v4, v8 all on bank 0
    set_op(0, 1, 0, 0, 0, 1); set_op(1, 1, 0, 0, 4, 1); set_op(2, 1, 0, 0, 8, 1);
    run_one("R7");
    chk("R7 literal", "stall", int'(out_stall), 2);
    chk("R1 literal", "used", int'(out_used), 12'h001);

    // R10: inputs change with in_valid low, result held
    begin
      int h_used, h_stall;
      h_used = e_used; h_stall = e_stall;
      set_op(0, 1, 1, 0, 6, 2); set_op(1, 1, 0, 0, 3, 4); set_op(2, 1, 1, 0, 22, 1);
      drive_ops();
      in_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R10", "out_valid", int'(out_valid), 0);
      chk("R10", "used", int'(out_used), h_used);
      chk("R10", "stall", int'(out_stall), h_stall);
    end

    // R5: scalar registers s0 and s1 share one pair, no conflict
    set_op(0, 1, 1, 0, 0, 1); set_op(1, 1, 1, 0, 1, 1); set_op(2, 0, 0, 0, 0, 0);
    run_one("R5");
    chk("R5 literal", "stall", int'(out_stall), 0);
    chk("R2 literal", "used", int'(out_used), 12'h010);

    // R5: v1 already read by the two-dword operand at v0
    set_op(0, 1, 0, 0, 0, 2); set_op(1, 1, 0, 0, 1, 1); set_op(2, 0, 0, 0, 0, 0);
    run_one("R5");
    chk("R5 literal", "op_mask", int'(out_op_mask[12 +: 12]), 0);

    // R6: an ignored slot neither stalls nor suppresses later units
    set_op(0, 1, 0, 1, 0, 1); set_op(1, 1, 0, 0, 0, 1); set_op(2, 1, 0, 0, 4, 1);
    run_one("R6");
    chk("R6 literal", "stall", int'(out_stall), 1);

    // R3: four dwords from v3 wrap across all vector banks; R4 scalar tuple wraps
    set_op(0, 1, 0, 0, 3, 7); set_op(1, 1, 1, 0, 14, 4); set_op(2, 0, 0, 0, 0, 0);
    run_one("R3");
    chk("R4 literal", "op_mask", int'(out_op_mask[12 +: 12]), 12'h810);

    // R1 R3 R5 R7: every pair of small vector operands
    for (int a = 0; a < 16; a++)
      for (int sa = 1; sa <= 4; sa++)
        for (int b = 0; b < 16; b++)
          for (int sb = 1; sb <= 4; sb++) begin
            set_op(0, 1, 0, 0, a, sa); set_op(1, 1, 0, 0, b, sb); set_op(2, 0, 0, 0, 0, 0);
            run_one("R1 R3 R5 R7 vector sweep");
          end

    // R2 R4 R5: every pair of small scalar operands
    for (int a = 0; a < 32; a++)
      for (int sa = 1; sa <= 4; sa++)
        for (int b = 0; b < 32; b++)
          for (int sb = 1; sb <= 4; sb++) begin
            set_op(0, 1, 1, 0, a, sa); set_op(1, 1, 1, 0, b, sb); set_op(2, 0, 0, 0, 0, 0);
            run_one("R2 R4 R5 scalar sweep");
          end

    // R6 R8 R9: mixed files, dead slots, zero and oversize sizes
    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < NOPS; k++)
        set_op(k, ($urandom % 5 != 0) ? 1 : 0, $urandom % 2, ($urandom % 6 == 0) ? 1 : 0,
               $urandom % 40, $urandom % 8);
      run_one("R6 R8 R9 mixed");
    end

    // R11: asynchronous reset clears a nonzero result
    set_op(0, 1, 0, 0, 0, 1); set_op(1, 1, 0, 0, 4, 1); set_op(2, 0, 0, 0, 0, 0);
    run_one("R11 preload");
    in_valid = 1'b0;
    #2 rst_n = 1'b0;
    #1;
    chk("R11", "out_valid", int'(out_valid), 0);
    chk("R11", "used", int'(out_used), 0);
    chk("R11", "stall", int'(out_stall), 0);
    finish_run();
  end

endmodule